// File: doc/BRIEF.md
# Multi-source wake interrupt arbiter

This block merges three active-low event lines into one active-low wake request for a small housekeeping controller. The lines are: a power adapter has been plugged in, a key is held down, and the host processor has come out of sleep. Each line has its own suppression flag. A line that is low while its flag is clear pulls the wake request low. The wake path is purely combinational from the raw pins. With no clock running, the request can still rouse a controller that has stopped its clock.

Once the controller is running, it pulses an acknowledge input. The block then takes a snapshot of every line that is active and not yet suppressed. It reports that snapshot as a pending bitmap and raises each of those flags, which releases the wake request. For each newly suppressed line it also fires a one-cycle service strobe. Each raw line is watched through a two-flop synchronizer. When a suppressed line returns high (adapter pulled, key let go, host asleep again), its flag drops, and a later assertion can wake the controller again. The service work itself (charging, key scanning) happens elsewhere.

All three are plain control pins. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `wake_arbiter`

## Requirements
- R1: While reset is asserted and right after it, every suppression flag, pending bit and service strobe is 0, and wake_n is 1 when all event lines are high.
- R2: wake_n is low exactly when at least one event line is low and its suppression flag is 0. This path has no clock delay.
- R3: On a clock edge with ack high, every event line that is synchronized-active and not suppressed has its flag set. Several lines are suppressed together at the same edge.
- R4: On each acknowledged edge, pending is loaded with the set of lines suppressed at that edge. Between acknowledges it holds its value. Bit 0 is the adapter line, bit 1 the key line and bit 2 the host line; svc and flags use the same order.
- R5: svc pulses high for exactly one cycle for each line, in the cycle its flag first reads 1.
- R6: A suppressed line's flag clears on the third rising edge after its raw input goes high: two edges of synchronizer, then one edge of flag update.
- R7: A suppressed line that stays low does not pull wake_n low, and a further acknowledge does not report it again. Only after it has gone high and been re-armed can it pull wake_n low again.
- R8: An event line is seen by the acknowledge logic only after two synchronizer edges. If ack is sampled at the second rising edge after the line fell, the line is not captured. If ack is sampled at the third, it is captured.
- R9: An acknowledge while no unsuppressed line is active clears pending to 0 and fires no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_n | input | 3 | Raw active-low event lines (bit 0 adapter, 1 key, 2 host) |
| ack | input | 1 | Wake acknowledge, sampled on the rising edge |
| wake_n | output | 1 | Combined active-low wake request, combinational |
| dis | output | 3 | Active-high suppression flag per line |
| svc | output | 3 | One-cycle service strobe per newly suppressed line |
| pending | output | 3 | Lines taken at the most recent acknowledge |

## Verification
The hardest case to reach is a line that is still held low while its flag is set. The wake request must stay released, a fresh acknowledge must not report the line again, and re-arming must wait until the line has truly been high for a full trip through the synchronizer. The stimulus holds the key line low across two acknowledges. It then raises the line and counts edges to the exact cycle the flag drops. It then lowers the line again to show the wake path is live once more. A separate scenario sets ack one edge too early after a line falls, to expose the synchronizer latency.

// File: rtl/wake_arb_pkg.sv
package wake_arb_pkg;
  localparam int unsigned SRC_COUNT = 3;
  localparam int unsigned SYNC_LEN  = 2;

  typedef enum int unsigned {
    SRC_ADAPTER = 0,
    SRC_KEY     = 1,
    SRC_HOST    = 2
  } src_idx_e;
endpackage

// File: rtl/wa_sync.sv
module wa_sync #(
  parameter int unsigned W     = 3,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_n,
  output logic [W-1:0] q_n
);
  logic [DEPTH-1:0][W-1:0] stg;

  // idle level of an active-low line is 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= d_n;
  end

  generate
    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[k] <= '1;
        else        stg[k] <= stg[k-1];
      end
    end
  endgenerate

  assign q_n = stg[DEPTH-1];
endmodule

// File: rtl/wa_src_slice.sv
module wa_src_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic act_s,
  input  logic ack,
  output logic cand,
  output logic dis,
  output logic svc
);
  assign cand = act_s & ~dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis <= 1'b0;
      svc <= 1'b0;
    end else begin
      svc <= ack & cand;
      if (ack && cand)
        dis <= 1'b1;
      else if (dis && !act_s)
        dis <= 1'b0;
    end
  end
endmodule

// File: rtl/wa_wake_comb.sv
module wa_wake_comb #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] raw_n,
  input  logic [N-1:0] dis,
  output logic         wake_n
);
  logic [N-1:0] pull;

  generate
    for (genvar i = 0; i < N; i++) begin : g_pull
      assign pull[i] = ~raw_n[i] & ~dis[i];
    end
  endgenerate

  assign wake_n = ~(|pull);
endmodule

// File: rtl/wake_arbiter.sv
module wake_arbiter #(
  parameter int unsigned NSRC       = wake_arb_pkg::SRC_COUNT,
  parameter int unsigned SYNC_DEPTH = wake_arb_pkg::SYNC_LEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_n,
  input  logic            ack,
  output logic            wake_n,
  output logic [NSRC-1:0] dis,
  output logic [NSRC-1:0] svc,
  output logic [NSRC-1:0] pending
);
  logic [NSRC-1:0] evt_s_n;
  logic [NSRC-1:0] cand;

  wa_sync #(.W(NSRC), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_n   (evt_n),
    .q_n   (evt_s_n)
  );

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      wa_src_slice u_slice (
        .clk   (clk),
        .rst_n (rst_n),
        .act_s (~evt_s_n[i]),
        .ack   (ack),
        .cand  (cand[i]),
        .dis   (dis[i]),
        .svc   (svc[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pending <= '0;
    else if (ack) pending <= cand;
  end

  wa_wake_comb #(.N(NSRC)) u_comb (
    .raw_n  (evt_n),
    .dis    (dis),
    .wake_n (wake_n)
  );
endmodule

// File: rtl/wake_arbiter_chk.sv
module wake_arbiter_chk #(
  parameter int unsigned NSRC       = 3,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] evt_n,
  input logic            ack,
  input logic            wake_n,
  input logic [NSRC-1:0] dis,
  input logic [NSRC-1:0] svc,
  input logic [NSRC-1:0] pending
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (dis == '0 && svc == '0 && pending == '0)
        else $error("R1 state not clear in reset");
    end
  end

  p_flag_rise_needs_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dis & ~$past(dis))) |-> $past(ack));

  p_pending_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ack) |-> $stable(pending));

  p_strobe_new_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|svc) |-> (((svc & ~dis) == '0) && ((svc & $past(dis)) == '0)));

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|svc) |=> ((svc & $past(svc)) == '0));

  p_all_off_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&dis) |-> wake_n);

  generate
    if (SYNC_DEPTH == 2) begin : g_rearm
      p_rearm_after_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(dis) & ~dis) & ~$past(evt_n, 2)) == '0));
    end
  endgenerate
endmodule

bind wake_arbiter wake_arbiter_chk #(.NSRC(NSRC), .SYNC_DEPTH(SYNC_DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt_n   (evt_n),
  .ack     (ack),
  .wake_n  (wake_n),
  .dis     (dis),
  .svc     (svc),
  .pending (pending)
);

// File: tb/wake_arbiter_test.sv
module wake_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] evt_n;
  logic       ack;
  logic       wake_n;
  logic [2:0] dis, svc, pending;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  wake_arbiter uut (
    .clk(clk), .rst_n(rst_n), .evt_n(evt_n), .ack(ack),
    .wake_n(wake_n), .dis(dis), .svc(svc), .pending(pending)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    step(1);
    ack = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; evt_n = 3'b111; ack = 1'b0;
    step(2);
    chk("R1 dis",     {29'd0, dis},     32'd0);
    chk("R1 pending", {29'd0, pending}, 32'd0);
    chk("R1 svc",     {29'd0, svc},     32'd0);
    chk("R1 wake_n",  {31'd0, wake_n},  32'd1);
    rst_n = 1'b1;
    step(1);
    chk("R1 dis after release", {29'd0, dis}, 32'd0);
  endtask

  task automatic t_single_adapter();
    evt_n = 3'b110;
    #1 chk("R2 wake low at once", {31'd0, wake_n}, 32'd0);
    step(2);
    pulse_ack();
    chk("R3 adapter flag",    {29'd0, dis},     32'h1);
    chk("R5 adapter strobe",  {29'd0, svc},     32'h1);
    chk("R4 adapter pending", {29'd0, pending}, 32'h1);
    chk("R7 wake released",   {31'd0, wake_n},  32'd1);
    step(1);
    chk("R5 strobe one cycle", {29'd0, svc},     32'h0);
    chk("R4 pending held",     {29'd0, pending}, 32'h1);
    evt_n = 3'b111;
    step(2);
    chk("R6 flag still set at edge 2", {29'd0, dis}, 32'h1);
    step(1);
    chk("R6 flag clear at edge 3",     {29'd0, dis}, 32'h0);
    chk("R4 pending held after rearm", {29'd0, pending}, 32'h1);
  endtask

  task automatic t_multi();
    evt_n = 3'b010;
    step(2);
    pulse_ack();
    chk("R3 two flags together", {29'd0, dis},     32'h5);
    chk("R4 two pending",        {29'd0, pending}, 32'h5);
    chk("R5 two strobes",        {29'd0, svc},     32'h5);
    evt_n = 3'b111;
    step(3);
    chk("R6 both rearmed", {29'd0, dis}, 32'h0);
  endtask

  task automatic t_sync_and_hold();
    evt_n = 3'b101;
    step(1);
    pulse_ack();
    chk("R8 early ack misses line", {29'd0, dis},     32'h0);
    chk("R8 early pending empty",   {29'd0, pending}, 32'h0);
    chk("R8 early no strobe",       {29'd0, svc},     32'h0);
    chk("R2 wake still low",        {31'd0, wake_n},  32'd0);
    pulse_ack();
    chk("R8 later ack captures",    {29'd0, dis},     32'h2);
    chk("R8 later pending",         {29'd0, pending}, 32'h2);
    step(4);
    chk("R7 held low stays released", {31'd0, wake_n}, 32'd1);
    chk("R7 flag kept",               {29'd0, dis},    32'h2);
    pulse_ack();
    chk("R7 not reported again", {29'd0, pending}, 32'h0);
    chk("R7 no second strobe",   {29'd0, svc},     32'h0);
    evt_n = 3'b111;
    step(3);
    chk("R6 key rearmed", {29'd0, dis}, 32'h0);
    evt_n = 3'b101;
    #1 chk("R7 rearmed line wakes", {31'd0, wake_n}, 32'd0);
    step(2);
    pulse_ack();
    chk("R5 key strobe after rearm", {29'd0, svc}, 32'h2);
    evt_n = 3'b111;
    step(3);
  endtask

  task automatic t_empty_ack();
    pulse_ack();
    chk("R9 pending cleared", {29'd0, pending}, 32'h0);
    chk("R9 no strobe",       {29'd0, svc},     32'h0);
    chk("R9 no flag",         {29'd0, dis},     32'h0);
    chk("R9 wake idle",       {31'd0, wake_n},  32'd1);
  endtask

  initial begin
    t_reset();
    t_single_adapter();
    t_multi();
    t_sync_and_hold();
    t_empty_ack();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule